// File: doc/BRIEF.md
# External Bus Access Splitter

This block takes a single CPU memory request and carries it out on a 16-bit external data bus. A request gives an address, a size (byte, half-word or word), a read/write flag, write data, a target area number and the width of the device in that area (8 or 16 bits). The block first checks alignment. A misaligned request is refused with an address-error pulse and does not reach the bus.

An aligned request is split into one, two or four bus cycles. Each cycle has its own address, its byte-lane strobes and, for writes, its data bytes. Each bus cycle ends when the bus answers with ready. For reads, the returned lanes are gathered into a 32-bit result.

Byte order is chosen per area by an 8-bit endian control register. One bit covers a group of areas. A set bit selects big-endian order. While the boot input is active, the bit for areas 9 and 10 reads back as zero and has no effect.

Top module: `ext_bus_splitter`

## Requirements
- R1: A request is accepted on a clock edge where `req_valid` is high and `req_ready` is high. It is misaligned if it is a half-word (size 1) with address bit 0 set, or a word (size 2) with address bits 1:0 not both zero. A misaligned request raises `addr_err` for the one cycle after acceptance, starts no bus cycle, and leaves the block idle. Byte requests (size 0) are never misaligned.
- R2: After reset, `cfg_rdata` is 0, `req_ready` is 1, and `bus_req`, `done` and `addr_err` are 0. All areas are then little-endian.
- R3: The endian bit is chosen by area number: areas 4–5 use bit 0, area 6 uses bit 1, areas 7–8 use bit 2, 9–10 bit 3, 11–12 bit 4, 13–14 bit 5, 15–16 bit 6, and 17–18 bit 7. A set bit means big-endian. Every other area is little-endian whatever the register holds.
- R4: While `boot_mode` is 1, bit 3 of `cfg_rdata` reads 0 and areas 9 and 10 are little-endian. Bit 3 itself is kept.
- R5: The number of bus cycles is as follows. On a 16-bit device, a word takes 2 and a half-word or byte takes 1. On an 8-bit device (`req_dev8`=1), a word takes 4, a half-word 2 and a byte 1.
- R6: For a byte access to a 16-bit device, the block strobes one lane only. In little-endian mode, an even address uses the low lane ([7:0], `bus_be_lo`) and an odd address uses the high lane ([15:8], `bus_be_hi`). Big-endian mode swaps the two. Half-word and word pieces strobe both lanes. In little-endian mode the even-address byte is on the low lane; in big-endian mode it is on the high lane.
- R7: An 8-bit device uses only lane [7:0] in little-endian areas and only lane [15:8] in big-endian areas. Only that lane is strobed and only that lane is read.
- R8: The pieces of a multi-cycle access go out at increasing addresses: +2 per cycle for a 16-bit device and +1 per cycle for an 8-bit device. The first piece uses the request address. In little-endian mode, the lowest address holds the least significant byte of the value. In big-endian mode, it holds the most significant byte.
- R9: `done` is high for exactly one cycle. That cycle follows the clock edge on which the final bus cycle saw `bus_ready`. On reads, `rdata` holds the assembled value during that cycle, zero-extended for byte and half-word sizes.
- R10: A write to the endian register through `cfg_we` applies only to requests accepted after the write edge. An access already under way keeps the byte order it started with.
- R11: While `bus_req` is high and `bus_ready` is low, the block holds the bus address, strobes and write data stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| boot_mode | input | 1 | Forces areas 9 and 10 to little-endian while high |
| cfg_we | input | 1 | Endian register write enable |
| cfg_wdata | input | 8 | Endian register write value |
| cfg_rdata | output | 8 | Effective endian register value |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be accepted |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 2 | 0 byte, 1 half-word, 2 word |
| req_write | input | 1 | 1 write, 0 read |
| req_wdata | input | 32 | Write value, right-aligned |
| req_area | input | 5 | Target area number |
| req_dev8 | input | 1 | Device in area is 8 bits wide |
| done | output | 1 | Access finished (one cycle) |
| rdata | output | 32 | Assembled read value |
| addr_err | output | 1 | Misaligned request refused (one cycle) |
| bus_req | output | 1 | Bus cycle requested |
| bus_write | output | 1 | Bus cycle is a write |
| bus_addr | output | ADDR_W | Bus cycle byte address |
| bus_wdata | output | 16 | Bus write data |
| bus_be_lo | output | 1 | Lane [7:0] strobe |
| bus_be_hi | output | 1 | Lane [15:8] strobe |
| bus_rdata | input | 16 | Bus read data |
| bus_ready | input | 1 | Bus cycle completes this edge |

## Verification
The first bus cycle appears in the cycle after the acceptance edge. `addr_err` is also due in that cycle, one register after acceptance. `done` and the full `rdata` come one cycle after the edge on which the last piece saw `bus_ready`. Piece k+1 appears in the cycle after piece k's ready edge.

The bench drives every input on falling edges and reads outputs on the next falling edge, so each value is read half a period after the edge that produced it. Each access task logs the index of the cycle where it granted the last ready and the index where `done` appeared. It checks that the gap is exactly one. A stalled piece is compared against itself one cycle later.

// File: rtl/ext_bus_splitter.sv
module ext_bus_splitter #(
  parameter int ADDR_W = 24,
  parameter int AREA_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boot_mode,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_write,
  input  logic [31:0]       req_wdata,
  input  logic [AREA_W-1:0] req_area,
  input  logic              req_dev8,
  output logic              done,
  output logic [31:0]       rdata,
  output logic              addr_err,
  output logic              bus_req,
  output logic              bus_write,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [15:0]       bus_wdata,
  output logic              bus_be_lo,
  output logic              bus_be_hi,
  input  logic [15:0]       bus_rdata,
  input  logic              bus_ready
);

  function automatic logic area_big(input logic [AREA_W-1:0] a, input logic [7:0] m);
    case (int'(a))
      4, 5:   return m[0];
      6:      return m[1];
      7, 8:   return m[2];
      9, 10:  return m[3];
      11, 12: return m[4];
      13, 14: return m[5];
      15, 16: return m[6];
      17, 18: return m[7];
      default: return 1'b0;
    endcase
  endfunction

  logic [7:0]        cfg_q;
  logic              busy_q, done_q, err_q;
  logic              big_q, dev8_q, wr_q;
  logic [1:0]        size_q, cnt_q, last_q;
  logic [ADDR_W-1:0] addr_q;
  logic [31:0]       wd_q, acc_q;

  assign cfg_rdata = {cfg_q[7:4], cfg_q[3] & ~boot_mode, cfg_q[2:0]};

  wire accept   = req_valid & ~busy_q;
  wire misalign = (req_size == 2'd1 && req_addr[0]) || (req_size[1] && req_addr[1:0] != 2'b00);
  wire [1:0] nbm1_d = req_size[1] ? 2'd3 : (req_size[0] ? 2'd1 : 2'd0);
  wire [1:0] last_d = req_dev8 ? nbm1_d : (req_size[1] ? 2'd1 : 2'd0);

  wire [1:0] nbm1   = size_q[1] ? 2'd3 : (size_q[0] ? 2'd1 : 2'd0);
  wire [1:0] off0   = dev8_q ? cnt_q : {cnt_q[0], 1'b0};
  wire       single = dev8_q | (size_q == 2'd0);
  wire       hi_sel = dev8_q ? big_q : (addr_q[0] ^ big_q);
  wire [1:0] one_idx = big_q ? nbm1 - off0 : off0;
  wire [1:0] lo_idx = single ? one_idx : (big_q ? nbm1 - off0 - 2'd1 : off0);
  wire [1:0] hi_idx = single ? one_idx : (big_q ? nbm1 - off0 : off0 + 2'd1);
  wire       step   = busy_q & bus_ready;

  assign req_ready = ~busy_q;
  assign done      = done_q;
  assign addr_err  = err_q;
  assign rdata     = acc_q;
  assign bus_req   = busy_q;
  assign bus_write = busy_q & wr_q;
  assign bus_addr  = addr_q + {{(ADDR_W-2){1'b0}}, off0};
  assign bus_wdata = {wd_q[{hi_idx, 3'b000} +: 8], wd_q[{lo_idx, 3'b000} +: 8]};
  assign bus_be_hi = busy_q & (~single | hi_sel);
  assign bus_be_lo = busy_q & (~single | ~hi_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      big_q  <= 1'b0;
      dev8_q <= 1'b0;
      wr_q   <= 1'b0;
      size_q <= '0;
      cnt_q  <= '0;
      last_q <= '0;
      addr_q <= '0;
      wd_q   <= '0;
      acc_q  <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (cfg_we) cfg_q <= cfg_wdata;
      if (accept) begin
        if (misalign) begin
          err_q <= 1'b1;
        end else begin
          busy_q <= 1'b1;
          big_q  <= area_big(req_area, cfg_rdata);
          dev8_q <= req_dev8;
          wr_q   <= req_write;
          size_q <= req_size;
          cnt_q  <= '0;
          last_q <= last_d;
          addr_q <= req_addr;
          wd_q   <= req_wdata;
          acc_q  <= '0;
        end
      end
      if (step) begin
        if (!wr_q) begin
          if (single) begin
            acc_q[{one_idx, 3'b000} +: 8] <= hi_sel ? bus_rdata[15:8] : bus_rdata[7:0];
          end else begin
            acc_q[{lo_idx, 3'b000} +: 8] <= bus_rdata[7:0];
            acc_q[{hi_idx, 3'b000} +: 8] <= bus_rdata[15:8];
          end
        end
        if (cnt_q == last_q) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 2'd1;
        end
      end
    end
  end

endmodule

module ext_bus_splitter_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              bus_req,
  input logic              bus_ready,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [15:0]       bus_wdata,
  input logic              bus_be_lo,
  input logic              bus_be_hi,
  input logic              done,
  input logic              addr_err
);

  a_r1_err_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
    addr_err |-> (!bus_req && req_ready));

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !bus_req);

  a_r11_hold_piece: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ready) |=> (bus_req && $stable(bus_addr) && $stable(bus_wdata)
                                 && $stable(bus_be_lo) && $stable(bus_be_hi)));

  a_r9_done_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(bus_req && bus_ready));

  a_r9_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r6_some_lane: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> (bus_be_lo || bus_be_hi));

endmodule

bind ext_bus_splitter ext_bus_splitter_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .bus_req(bus_req),
  .bus_ready(bus_ready), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_be_lo(bus_be_lo), .bus_be_hi(bus_be_hi), .done(done), .addr_err(addr_err)
);

// File: tb/ext_bus_splitter_test.sv
module ext_bus_splitter_test;
  localparam int AW = 24;

  logic clk = 0, rst_n = 0, boot_mode = 0, cfg_we = 0;
  logic [7:0] cfg_wdata = 0, cfg_rdata;
  logic req_valid = 0, req_ready, req_write = 0, req_dev8 = 0;
  logic [AW-1:0] req_addr = 0;
  logic [1:0] req_size = 0;
  logic [31:0] req_wdata = 0, rdata;
  logic [4:0] req_area = 0;
  logic done, addr_err, bus_req, bus_write, bus_be_lo, bus_be_hi;
  logic [AW-1:0] bus_addr;
  logic [15:0] bus_wdata, bus_rdata = 0;
  logic bus_ready = 0;

  ext_bus_splitter #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .boot_mode(boot_mode), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .req_size(req_size),
    .req_write(req_write), .req_wdata(req_wdata), .req_area(req_area),
    .req_dev8(req_dev8), .done(done), .rdata(rdata), .addr_err(addr_err),
    .bus_req(bus_req), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_be_lo(bus_be_lo), .bus_be_hi(bus_be_hi),
    .bus_rdata(bus_rdata), .bus_ready(bus_ready)
  );

  always #10 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  logic [AW-1:0] la [8];
  logic [15:0] lw [8];
  logic [1:0] lbe [8];
  logic [15:0] rsp [8];
  int n;
  bit got_done, got_err;
  logic [31:0] rv;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog expired act=%0d exp=<100000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", what, act, exp);
    end
  endtask

  task automatic set_cfg(input logic [7:0] v);
    @(negedge clk); cfg_we = 1; cfg_wdata = v;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic run(input logic [4:0] area, input bit dev8, input logic [1:0] size,
                     input logic [AW-1:0] addr, input bit wr, input logic [31:0] wd,
                     input bit poke, input logic [7:0] poke_val, input bit stall);
    int last_t, done_t, stalled;
    bit poked;
    logic [AW-1:0] sa;
    last_t = -10; done_t = -20; stalled = 0; poked = 0; sa = '0;
    @(negedge clk);
    req_valid = 1; req_area = area; req_dev8 = dev8; req_size = size;
    req_addr = addr; req_write = wr; req_wdata = wd;
    @(negedge clk);
    req_valid = 0;
    n = 0; got_done = 0; got_err = 0; rv = '0;
    for (int t = 0; t < 40; t++) begin
      if (addr_err) got_err = 1;
      if (done) begin got_done = 1; rv = rdata; done_t = t; break; end
      if (got_err && t > 4) break;
      if (bus_req && n < 8) begin
        if (stall && stalled == 0) begin
          stalled = 1; sa = bus_addr; bus_ready = 0;
        end else begin
          if (stalled == 1) begin
            chk("R11 address held while not ready", bus_addr, sa);
            stalled = 2;
          end
          la[n] = bus_addr; lw[n] = bus_wdata; lbe[n] = {bus_be_hi, bus_be_lo};
          bus_rdata = rsp[n]; bus_ready = 1; n++; last_t = t;
        end
        if (poke && !poked && n == 1) begin
          cfg_we = 1; cfg_wdata = poke_val; poked = 1;
        end
      end
      @(negedge clk);
      bus_ready = 0; cfg_we = 0;
    end
    if (got_done) chk("R9 done one cycle after final ready", done_t - last_t, 1);
  endtask

  task automatic t_reset;
    chk("R2 req_ready after reset", req_ready, 1);
    chk("R2 bus_req after reset", bus_req, 0);
    chk("R2 cfg_rdata after reset", cfg_rdata, 0);
    chk("R2 done after reset", done, 0);
    chk("R2 addr_err after reset", addr_err, 0);
  endtask

  task automatic t_word16;
    set_cfg(8'h00);
    run(5'd4, 0, 2'd2, 24'h100, 1, 32'h11223344, 0, 0, 0);
    chk("R5 word on 16-bit takes 2", n, 2);
    chk("R8 piece0 addr", la[0], 24'h100);
    chk("R8 piece1 addr", la[1], 24'h102);
    chk("R2 R8 LE piece0 data", lw[0], 16'h3344);
    chk("R8 LE piece1 data", lw[1], 16'h1122);
    chk("R6 word piece both lanes", lbe[0], 2'b11);
    chk("R9 done seen", got_done, 1);
    set_cfg(8'h01);
    rsp[0] = 16'hAABB; rsp[1] = 16'hCCDD;
    run(5'd4, 0, 2'd2, 24'h200, 0, 0, 0, 0, 0);
    chk("R3 R9 BE word read", rv, 32'hAABBCCDD);
    chk("R8 BE piece1 addr", la[1], 24'h202);
    set_cfg(8'h00);
    run(5'd5, 0, 2'd2, 24'h200, 0, 0, 0, 0, 0);
    chk("R3 LE word read", rv, 32'hCCDDAABB);
  endtask

  task automatic t_byte16;
    set_cfg(8'h00);
    run(5'd6, 0, 2'd0, 24'h301, 1, 32'h5A, 0, 0, 0);
    chk("R5 byte on 16-bit takes 1", n, 1);
    chk("R6 LE odd uses high lane", lbe[0], 2'b10);
    chk("R6 LE odd data on high lane", lw[0][15:8], 8'h5A);
    set_cfg(8'h02);
    run(5'd6, 0, 2'd0, 24'h300, 1, 32'h5A, 0, 0, 0);
    chk("R6 BE even uses high lane", lbe[0], 2'b10);
    run(5'd6, 0, 2'd0, 24'h301, 1, 32'h5A, 0, 0, 0);
    chk("R6 BE odd uses low lane", lbe[0], 2'b01);
    chk("R6 BE odd data on low lane", lw[0][7:0], 8'h5A);
  endtask

  task automatic t_zext;
    set_cfg(8'h00);
    rsp[0] = 16'hC37E;
    run(5'd6, 0, 2'd0, 24'h401, 0, 0, 0, 0, 0);
    chk("R9 R6 byte read odd zero-extended", rv, 32'h000000C3);
    run(5'd6, 0, 2'd0, 24'h400, 0, 0, 0, 0, 0);
    chk("R9 R6 byte read even zero-extended", rv, 32'h0000007E);
    rsp[0] = 16'hBEEF;
    run(5'd6, 0, 2'd1, 24'h10, 0, 0, 0, 0, 0);
    chk("R5 half on 16-bit takes 1", n, 1);
    chk("R9 half read zero-extended", rv, 32'h0000BEEF);
  endtask

  task automatic t_dev8;
    set_cfg(8'h00);
    rsp[0] = 16'h0011; rsp[1] = 16'h0022; rsp[2] = 16'h0033; rsp[3] = 16'h0044;
    run(5'd7, 1, 2'd2, 24'h500, 0, 0, 0, 0, 0);
    chk("R5 word on 8-bit takes 4", n, 4);
    chk("R8 8-bit piece3 addr", la[3], 24'h503);
    chk("R7 LE 8-bit low lane only", lbe[2], 2'b01);
    chk("R7 R8 LE 8-bit word read", rv, 32'h44332211);
    set_cfg(8'h04);
    rsp[0] = 16'h1100; rsp[1] = 16'h2200; rsp[2] = 16'h3300; rsp[3] = 16'h4400;
    run(5'd8, 1, 2'd2, 24'h500, 0, 0, 0, 0, 0);
    chk("R7 R8 BE 8-bit word read", rv, 32'h11223344);
    chk("R7 BE 8-bit high lane only", lbe[0], 2'b10);
    run(5'd8, 1, 2'd1, 24'h600, 1, 32'hABCD, 0, 0, 0);
    chk("R5 half on 8-bit takes 2", n, 2);
    chk("R8 BE 8-bit half first byte", lw[0][15:8], 8'hAB);
    chk("R8 BE 8-bit half second byte", lw[1][15:8], 8'hCD);
    chk("R8 8-bit piece1 addr", la[1], 24'h601);
    set_cfg(8'h00);
    rsp[0] = 16'hFF99;
    run(5'd7, 1, 2'd0, 24'h703, 0, 0, 0, 0, 0);
    chk("R5 byte on 8-bit takes 1", n, 1);
    chk("R7 LE 8-bit ignores high lane", rv, 32'h00000099);
  endtask

  task automatic t_misalign;
    run(5'd4, 0, 2'd1, 24'h11, 0, 0, 0, 0, 0);
    chk("R1 half odd raises addr_err", got_err, 1);
    chk("R1 half odd no bus cycle", n, 0);
    chk("R1 half odd no done", got_done, 0);
    run(5'd4, 0, 2'd2, 24'h102, 1, 32'h1, 0, 0, 0);
    chk("R1 word addr 2 raises addr_err", got_err, 1);
    chk("R1 word addr 2 no bus cycle", n, 0);
    run(5'd4, 1, 2'd2, 24'h103, 0, 0, 0, 0, 0);
    chk("R1 word addr 3 raises addr_err", got_err, 1);
    chk("R1 idle after error", req_ready, 1);
    run(5'd4, 0, 2'd0, 24'h103, 0, 0, 0, 0, 0);
    chk("R1 byte odd no error", got_err, 0);
  endtask

  task automatic t_boot;
    boot_mode = 1;
    set_cfg(8'h08);
    chk("R4 bit3 reads 0 in boot", cfg_rdata, 8'h00);
    run(5'd9, 0, 2'd2, 24'h800, 1, 32'h11223344, 0, 0, 0);
    chk("R4 area 9 LE in boot", lw[0], 16'h3344);
    @(negedge clk); boot_mode = 0;
    @(negedge clk);
    chk("R4 bit3 kept after boot", cfg_rdata, 8'h08);
    run(5'd10, 0, 2'd2, 24'h800, 1, 32'h11223344, 0, 0, 0);
    chk("R3 area 10 BE after boot", lw[0], 16'h1122);
  endtask

  task automatic t_unlisted;
    set_cfg(8'hFF);
    run(5'd2, 0, 2'd2, 24'h900, 1, 32'h11223344, 0, 0, 0);
    chk("R3 area 2 always LE", lw[0], 16'h3344);
    run(5'd19, 0, 2'd2, 24'h900, 1, 32'h11223344, 0, 0, 0);
    chk("R3 area 19 always LE", lw[0], 16'h3344);
    run(5'd18, 0, 2'd2, 24'h900, 1, 32'h11223344, 0, 0, 0);
    chk("R3 area 18 uses bit 7", lw[0], 16'h1122);
    set_cfg(8'h7F);
    run(5'd17, 0, 2'd2, 24'h900, 1, 32'h11223344, 0, 0, 0);
    chk("R3 area 17 LE with bit 7 clear", lw[0], 16'h3344);
  endtask

  task automatic t_late_cfg;
    set_cfg(8'h00);
    run(5'd4, 0, 2'd2, 24'hA00, 1, 32'h11223344, 1, 8'h01, 0);
    chk("R10 write during access keeps order", lw[1], 16'h1122);
    chk("R10 register updated", cfg_rdata, 8'h01);
    run(5'd4, 0, 2'd2, 24'hA00, 1, 32'h11223344, 0, 0, 0);
    chk("R10 next access uses new order", lw[0], 16'h1122);
  endtask

  task automatic t_stall;
    set_cfg(8'h00);
    run(5'd4, 0, 2'd2, 24'hB00, 1, 32'hCAFEF00D, 0, 0, 1);
    chk("R11 stalled access still 2 pieces", n, 2);
    chk("R11 stalled piece0 data", lw[0], 16'hF00D);
    chk("R11 stalled piece1 addr", la[1], 24'hB02);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) rsp[i] = '0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    t_word16;
    t_byte16;
    t_zext;
    t_dev8;
    t_misalign;
    t_boot;
    t_unlisted;
    t_late_cfg;
    t_stall;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule